// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a two-wire serial bus (I2C-compatible) target that gives an external host read and write access to a bank of 8-bit configuration registers. SCL and SDA are sampled with a fast system clock. Each line passes through a two-flop synchronizer and a three-sample majority vote before start, stop and clock edges are detected. The block pulls SDA low through an output-enable; the pad or the board supplies the pull-up. Every register is also presented on a flat parallel bus, so the surrounding logic sees each setting as soon as it is written.

The 7-bit bus address is fixed except for its lowest bit, which comes from a strap pin. A write transfer carries a register index followed by data bytes. The index advances by one after each stored byte. A read transfer is made by writing the index, issuing a repeated start, and then addressing the target with the read bit set. The block has defined behaviour at the top of the register space. An index that is out of range is refused. Reads that run off the end keep returning the last register. Writes that run off the end are refused and the transfer ends.

Top module: `cfg_i2c_target`

## Requirements
- R1: A start is a falling SDA while SCL is high, and a stop is a rising SDA while SCL is high. Either condition, seen at any point in a transfer, abandons that transfer and releases SDA. After a start, the next byte is decoded as a new address byte.
- R2: The first byte after a start is sent MSB first. Its upper seven bits are compared with {6'b110101, strap}, so the write/read bus bytes are 0xD4/0xD5 for strap 0 and 0xD6/0xD7 for strap 1. On a match the target pulls SDA low for the ninth clock. On a mismatch it gives no acknowledge and ignores all bytes until the next start.
- R3: In a write transfer the second byte is the register index. An index from 0x00 to 0x3F is acknowledged and loaded as the index pointer. An index of 0x40 or above gets no acknowledge, and the target drops to idle.
- R4: Each later write byte is stored at the pointer, the pointer then increments by one, and the byte is acknowledged. Register i appears on the parallel bus at bits [8*i+7:8*i].
- R5: A write byte that arrives when the pointer has passed 0x3F is not stored. It gets no acknowledge, and the target goes idle, so later bytes are not acknowledged either.
- R6: With bit 0 of the address byte set to 1, the target sends the register at the pointer MSB first. It moves to the next register each time the master acknowledges, and it releases SDA and goes idle when the master does not acknowledge.
- R7: During a read, once the pointer has reached 0x3F, every further byte is the contents of register 0x3F.
- R8: After reset, all registers hold 0x00 and SDA is released.
- R9: The SDA output-enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Sets the lowest bit of the bus address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_flat | output | REG_COUNT*8 | All registers side by side, register i at bits [8*i+7:8*i] |

## Verification
The assertions assume that SCL stays at each level for many more system clocks than the synchronizer and vote pipeline is deep. They also assume that SDA from the master changes only while SCL is well settled. Under those conditions a filtered SDA edge never lands in the same cycle as a filtered SCL edge, so the output-enable can only move after SCL has been seen low. The bench holds every bus phase for ten system clocks. It changes SDA only in the middle of a low or high SCL phase, keeps the strap steady while the bus is idle, and always ends a read with a not-acknowledge, so that the target never holds SDA low across a stop or start.

// File: rtl/cfg_i2c_pkg.sv
// Package: shared types for the two-wire register target.
// Assumes byte-wide registers; the protocol state names live here.
package cfg_i2c_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_DEVA,   // shifting in the address byte
        ST_SUBA,   // shifting in the register index
        ST_WDAT,   // shifting in a write byte
        ST_ACK,    // target drives the ninth-bit acknowledge
        ST_RDAT,   // target shifts out a read byte
        ST_MACK,   // master answers on the ninth bit
        ST_RLOAD   // master acked: drive the next byte at SCL fall
    } link_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Module: i2c_line_filter
// Synchronizes one open-drain line, removes single-sample glitches with
// a majority vote, and reports the filtered level and its edges.
// Assumes SYNC_STAGES >= 2 and an odd VOTE_TAPS >= 3. The line idles high.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(VOTE_TAPS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   win_q;
    logic                   prev_q;
    logic [CW-1:0]          ones;
    logic                   vote;

    // Count the ones in the window and take the majority.
    always_comb begin
        ones = '0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            ones = ones + CW'(win_q[i]);
        end
        vote = (ones > CW'(VOTE_TAPS / 2));
    end

    // Synchronizer, vote window, filtered level and its delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '1;
            win_q   <= '1;
            level_o <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q   <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            level_o <= vote;
            prev_q  <= level_o;
        end
    end

    assign rise_o = level_o & ~prev_q;
    assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// A bank of byte registers, each loaded by a single-cycle write strobe.
// All registers are shown on one flat bus. Assumes wr_idx < REG_COUNT.
module cfg_reg_bank #(
    parameter int REG_COUNT = 64,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [REG_COUNT*8-1:0] regs_flat
);
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        // One register: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_flat[g*8 +: 8] <= 8'h00;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs_flat[g*8 +: 8] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/i2c_target_fsm.sv
// Module: i2c_target_fsm
// Bus protocol engine: address match, index load, auto-increment writes
// and reads, and acknowledges. SDA changes are made on the cycle that
// follows a detected SCL fall. Assumes filtered, edge-detected inputs.
module i2c_target_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int         REG_COUNT      = 64,
    parameter logic [5:0] DEV_ADDR_UPPER = 6'h35,
    localparam int IDX_W = $clog2(REG_COUNT),
    localparam int PTR_W = IDX_W + 1,
    localparam int TOP   = REG_COUNT - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   sda_lvl,
    input  logic                   start_det,
    input  logic                   stop_det,
    input  logic                   strap,
    input  logic [REG_COUNT*8-1:0] regs_flat,
    output logic                   sda_oe,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [7:0]             wr_data
);
    link_state_t       state, nxt;
    logic [2:0]        cnt;
    logic [7:0]        rx, tx;
    logic [PTR_W-1:0]  ptr;
    logic              ack_on;
    logic [7:0]        rx_byte;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_byte;

    // Byte being completed and the register to read (saturated at the top).
    always_comb begin
        rx_byte = {rx[6:0], sda_lvl};
        rd_idx  = (int'(ptr) > TOP) ? IDX_W'(TOP) : ptr[IDX_W-1:0];
        rd_byte = regs_flat[{rd_idx, 3'b000} +: 8];
    end

    // Protocol sequencer: bit counting, decisions, SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            cnt     <= '0;
            rx      <= '0;
            tx      <= '0;
            ptr     <= '0;
            ack_on  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_DEVA;
                cnt    <= '0;
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: sda_oe <= 1'b0;
                    ST_DEVA, ST_SUBA, ST_WDAT: begin
                        if (scl_rise) begin
                            rx  <= rx_byte;
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) begin
                                ack_on <= 1'b0;
                                state  <= ST_IDLE;
                                if (state == ST_DEVA) begin
                                    if (rx_byte[7:1] == {DEV_ADDR_UPPER, strap}) begin
                                        state <= ST_ACK;
                                        nxt   <= rx_byte[0] ? ST_RDAT : ST_SUBA;
                                    end
                                end else if (state == ST_SUBA) begin
                                    if (int'(rx_byte) < REG_COUNT) begin
                                        ptr   <= PTR_W'(rx_byte);
                                        state <= ST_ACK;
                                        nxt   <= ST_WDAT;
                                    end
                                end else if (int'(ptr) < REG_COUNT) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr[IDX_W-1:0];
                                    wr_data <= rx_byte;
                                    ptr     <= ptr + PTR_W'(1);
                                    state   <= ST_ACK;
                                    nxt     <= ST_WDAT;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                sda_oe <= 1'b1;
                                ack_on <= 1'b1;
                            end else begin
                                ack_on <= 1'b0;
                                cnt    <= '0;
                                state  <= nxt;
                                if (nxt == ST_RDAT) begin
                                    tx     <= rd_byte;
                                    sda_oe <= ~rd_byte[7];
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end else if (scl_rise) begin
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) begin
                                state  <= ST_MACK;
                                ack_on <= 1'b0;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_fall && !ack_on) begin
                            sda_oe <= 1'b0;
                            ack_on <= 1'b1;
                        end else if (scl_rise && ack_on) begin
                            if (!sda_lvl) begin
                                state <= ST_RLOAD;
                                ptr   <= (int'(ptr) < TOP) ? ptr + PTR_W'(1) : PTR_W'(TOP);
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_RLOAD: begin
                        if (scl_fall) begin
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            cnt    <= '0;
                            state  <= ST_RDAT;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_i2c_target.sv
// Module: cfg_i2c_target (top)
// Two-wire bus target that exposes a bank of byte registers. It combines
// the line filters, the start/stop detector, the protocol engine and the
// register bank. Assumes clk runs many times faster than SCL.
module cfg_i2c_target #(
    parameter int         REG_COUNT      = 64,
    parameter logic [5:0] DEV_ADDR_UPPER = 6'h35,
    parameter int         SYNC_STAGES    = 2,
    parameter int         VOTE_TAPS      = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   addr_strap,
    output logic                   sda_oe,
    output logic [REG_COUNT*8-1:0] regs_flat
);
    localparam int IDX_W = $clog2(REG_COUNT);

    logic             scl_f, scl_rise, scl_fall;
    logic             sda_f, sda_rise, sda_fall;
    logic             start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_f), .rise_o(scl_rise), .fall_o(scl_fall));

    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_f), .rise_o(sda_rise), .fall_o(sda_fall));

    // Bus conditions: an SDA edge while SCL is held high.
    assign start_det = sda_fall & scl_f;
    assign stop_det  = sda_rise & scl_f;

    i2c_target_fsm #(.REG_COUNT(REG_COUNT), .DEV_ADDR_UPPER(DEV_ADDR_UPPER)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_f),
        .start_det(start_det), .stop_det(stop_det), .strap(addr_strap),
        .regs_flat(regs_flat), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

    cfg_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_flat(regs_flat));
endmodule

// File: rtl/cfg_i2c_target_chk.sv
// Module: cfg_i2c_target_chk
// Protocol properties of the register target, bound to the top module.
// Assumes SCL phases much longer than the filter pipeline.
module cfg_i2c_target_chk #(
    parameter int REG_COUNT = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_f,
    input logic                   scl_rise,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   sda_oe,
    input logic                   wr_en,
    input logic [REG_COUNT*8-1:0] regs_flat
);
    // R9: the SDA drive moves only when SCL has been seen low.
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_f));

    // R1: a stop leaves SDA released.
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R1: a start leaves SDA released.
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R4: a store is issued only right after an SCL rise.
    a_r4_store_on_scl_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_rise));

    // R4: with no store strobe the registers hold their values.
    a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_rise(scl_rise),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
    .wr_en(wr_en), .regs_flat(regs_flat));

// File: tb/tb_cfg_i2c_target.sv
// Bench: a bus master drives transfers, and a behavioural register model
// predicts the acknowledges, read data and register contents.
module tb_cfg_i2c_target;
    localparam int NREG = 64;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs_flat;
    wire  sda_bus = sda_m & ~sda_oe;

    int tests = 0;
    int fails = 0;
    int mreg[NREG];
    int mptr = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] dq[$];

    always #2 clk = ~clk;

    cfg_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_strap(strap), .sda_oe(sda_oe), .regs_flat(regs_flat));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Every clock: registers against the model while the bus is quiet.
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            bit bad = 1'b0;
            int bi = 0;
            for (int i = 0; i < NREG; i++) begin
                if (int'(regs_flat[i*8 +: 8]) != mreg[i] && !bad) begin
                    bad = 1'b1;
                    bi = i;
                end
            end
            check(!bad, "R4", $sformatf("reg %0h", bi), int'(regs_flat[bi*8 +: 8]), mreg[bi]);
        end
    end

    // Every clock: the SDA drive changes only while SCL is low (R9).
    always @(negedge clk) begin
        if (rst_n && !done && sda_oe != prev_oe)
            check(scl_m == 1'b0, "R9", "sda_oe change with scl", int'(scl_m), 0);
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic put_bit(input logic b);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q / 2);
        @(negedge clk); b = sda_bus; tick(Q / 2); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        acked = (a == 1'b0);
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(~master_ack);
    endtask

    // Write transfer: address byte, index, then the bytes queued in dq.
    task automatic wr_seq(input logic [7:0] abyte, input int sub);
        bit ack, alive, expa;
        cmp_on = 1'b0;
        bus_start();
        expa = (abyte[7:1] == {6'h35, strap}) && !abyte[0];
        send_byte(abyte, ack);
        check(ack == expa, "R2", $sformatf("address %0h ack", abyte), ack, expa);
        alive = expa && (sub < NREG);
        send_byte(8'(sub), ack);
        check(ack == alive, "R3", $sformatf("index %0h ack", sub), ack, alive);
        if (alive) mptr = sub;
        foreach (dq[k]) begin
            bit expd = alive && (mptr < NREG);
            send_byte(dq[k], ack);
            check(ack == expd, expd ? "R4" : "R5", $sformatf("data ack at %0h", mptr), ack, expd);
            if (expd) begin
                mreg[mptr] = int'(dq[k]);
                mptr++;
            end else begin
                alive = 1'b0;
            end
        end
        bus_stop();
        tick(Q);
        cmp_on = 1'b1;
    endtask

    // Read transfer: set the index, repeated start, read n bytes, NACK last.
    task automatic rd_seq(input int sub, input int n);
        bit ack;
        logic [7:0] b;
        cmp_on = 1'b0;
        bus_start();
        send_byte({6'h35, strap, 1'b0}, ack);
        check(ack, "R2", "address ack before read", ack, 1);
        send_byte(8'(sub), ack);
        check(ack, "R3", "read index ack", ack, 1);
        mptr = sub;
        bus_start();
        send_byte({6'h35, strap, 1'b1}, ack);
        check(ack, "R6", "read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            int idx = (mptr > NREG - 1) ? NREG - 1 : mptr;
            recv_byte(i < n - 1, b);
            check(int'(b) == mreg[idx], (idx == NREG - 1) ? "R7" : "R6",
                  $sformatf("read byte %0d", i), int'(b), mreg[idx]);
            if (i < n - 1) mptr = (mptr < NREG - 1) ? mptr + 1 : NREG - 1;
        end
        tick(Q);
        check(sda_oe == 1'b0, "R6", "released after master nack", sda_oe, 0);
        bus_stop();
        cmp_on = 1'b1;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) mreg[i] = 0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R8: reset state
        check(sda_oe == 1'b0, "R8", "sda released after reset", sda_oe, 0);
        check(regs_flat == '0, "R8", "registers clear after reset", int'(regs_flat[7:0]), 0);
        cmp_on = 1'b1;

        // R4: plain writes, then R6 read back
        dq = '{8'hA5, 8'h3C, 8'h0F};
        wr_seq(8'hD4, 8'h05);
        rd_seq(8'h05, 3);

        // R2: wrong address ignored, later bytes not acknowledged
        dq = '{8'h11, 8'h22};
        wr_seq(8'hD6, 8'h10);

        // R2: strap selects the other address
        strap = 1'b1;
        tick(Q);
        dq = '{8'h77};
        wr_seq(8'hD6, 8'h10);
        rd_seq(8'h10, 1);
        dq = '{8'h99};
        wr_seq(8'hD4, 8'h11);
        strap = 1'b0;
        tick(Q);

        // R3: out-of-range index refused
        dq = '{8'h55};
        wr_seq(8'hD4, 8'h40);
        dq = '{8'h66};
        wr_seq(8'hD4, 8'hFF);

        // R5: writing past the top register
        dq = '{8'hE1, 8'hF2, 8'hD3, 8'hC4};
        wr_seq(8'hD4, 8'h3E);

        // R7: reads past the top repeat the top register
        rd_seq(8'h3D, 5);

        // R2: read address for the other strap value is not acknowledged
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'hD4, ack);
        send_byte(8'h05, ack);
        bus_start();
        send_byte(8'hD7, ack);
        check(!ack, "R2", "read with foreign address", ack, 0);
        bus_stop();
        cmp_on = 1'b1;

        // R1: start in mid-byte aborts; the next address is decoded afresh
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'hD4, ack);
        send_byte(8'h20, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte(8'hD4, ack);
        check(ack, "R1", "address after repeated start mid-byte", ack, 1);
        send_byte(8'h21, ack);
        mptr = 8'h21;
        send_byte(8'h4B, ack);
        check(ack, "R1", "data after abort", ack, 1);
        mreg[8'h21] = 8'h4B;
        mptr++;
        // R1: stop in mid-byte abandons the byte
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_stop();
        tick(Q);
        check(sda_oe == 1'b0, "R1", "released after stop", sda_oe, 0);
        cmp_on = 1'b1;
        tick(Q);
        rd_seq(8'h20, 3);

        // R1: after a stop, data without a start is ignored
        cmp_on = 1'b0;
        send_byte(8'hD4, ack);
        check(!ack, "R1", "byte without start", ack, 0);
        bus_stop();
        cmp_on = 1'b1;

        // R8: reset in the middle of operation clears everything
        cmp_on = 1'b0;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) mreg[i] = 0;
        mptr = 0;
        tick(2);
        check(regs_flat == '0, "R8", "registers clear after second reset", int'(regs_flat[8'h05*8 +: 8]), 0);
        check(sda_oe == 1'b0, "R8", "sda released after second reset", sda_oe, 0);
        cmp_on = 1'b1;
        rd_seq(8'h05, 1);
        tick(20);
        summary();
    end
endmodule